// File: doc/BRIEF.md
# Two-Way Set-Associative Copy-Back Data Cache

This block is a small data cache that sits between a processor request port and a slower, word-addressed main-memory port. Storage is organised as sets of two ways, with one multi-word line per way. Both ways of the addressed set are looked up in the same cycle. A request that matches a valid line completes in the cycle it is presented. A request that misses fetches the whole line from memory into a chosen way and is then replayed, so it completes as a hit.

Writes that hit touch only the cache and mark the line modified. A modified line goes back to memory only when it is displaced. When that happens the line is copied in one cycle into a one-line write buffer, which drains to memory on its own write port while the cache carries on. A single bit per set records which way was used less recently. The processor holds its request stable until `cpu_done` pulses. Addresses are word addresses split as tag | set | word offset, with the word offset in the least significant bits.

Top module: `cwb_cache`

## Requirements
- R1: After reset no line is valid, `cpu_done` is low, and neither memory request is raised while no request is pending. The first access to any set misses and fetches its line.
- R2: A request whose tag matches a valid line in either way of its set raises `cpu_done` in the same cycle with no memory traffic. For a read, `cpu_rdata` carries the addressed word.
- R3: On a miss the block reads the four words of the requested line from memory, one handshake each, at word offsets 0, 1, 2, 3 of the line base. It then replays the access, which completes as a hit. `cpu_done` stays low during the fetch.
- R4: The way to refill is way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the least recently used way of the set. Every hit and every completed fill makes the other way the least recently used one.
- R5: A write hit updates only the cache word. Main memory is not written until the line is displaced.
- R6: Displacing a modified line writes its four words, offsets 0 to 3 in order, to its own line address through the write buffer. Displacing an unmodified line causes no memory write.
- R7: The access that displaced a modified line completes without waiting for the write buffer to drain.
- R8: A miss whose line is still held in the write buffer waits until the buffer has drained, then fetches the line and returns the data that was written back. A fetch never runs for the line the buffer holds.
- R9: While a memory request is raised and not acknowledged, its address and write data stay stable.
- R10: A write miss first fetches the line and then writes the word into the cache only. The other words of the line keep their memory values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request pending; held until cpu_done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address: tag, set, offset |
| req_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_done |
| mem_rd_req | output | 1 | Line fetch word request |
| mem_rd_addr | output | ADDR_W | Word address of the fetch |
| mem_rd_ack | input | 1 | Fetch word accepted, data present |
| mem_rd_data | input | DATA_W | Fetched word |
| mem_wr_req | output | 1 | Write buffer word request |
| mem_wr_addr | output | ADDR_W | Word address of the write |
| mem_wr_data | output | DATA_W | Word written back |
| mem_wr_ack | input | 1 | Write word accepted |

## Verification
The bench goes after way choice and recency. After one way of a set is touched, a third line must displace the other way. A design with the recency bit inverted would drop the line that was just used, and its next access would miss. It checks that a modified line reaches memory only on displacement, at offsets 0 to 3 of its own base. An early write-through, or a write to the new line's address, shows up in the memory contents. With the memory write port held off, it re-reads a line that sits in the write buffer. A design that fetched at once would return the stale memory word, and one that waited on every buffered eviction would stall the displacing access too.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
   localparam int WAYS = 2;
   typedef enum logic {ST_LOOK, ST_FILL} cwb_state_t;
endpackage

// File: rtl/cwb_way.sv
// One way of the cache: valid, dirty, tag and data storage for every set,
// plus the tag comparison for the addressed set.
module cwb_way #(
   parameter int DATA_W   = 32,
   parameter int SET_BITS = 2,
   parameter int OFF_BITS = 2,
   parameter int TAG_W    = 4,
   localparam int SETS    = 1 << SET_BITS,
   localparam int WORDS   = 1 << OFF_BITS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [SET_BITS-1:0]     set_i,
   input  logic [OFF_BITS-1:0]     off_i,
   input  logic [TAG_W-1:0]        tag_i,
   output logic                    hit_o,
   output logic                    valid_o,
   output logic                    dirty_o,
   output logic [TAG_W-1:0]        tag_o,
   output logic [DATA_W-1:0]       word_o,
   output logic [WORDS*DATA_W-1:0] line_o,
   input  logic                    wr_en_i,
   input  logic [DATA_W-1:0]       wr_data_i,
   input  logic                    fill_en_i,
   input  logic                    fill_last_i,
   input  logic [OFF_BITS-1:0]     fill_off_i,
   input  logic [DATA_W-1:0]       fill_data_i
);
   logic [SETS-1:0]   valid_q;
   logic [SETS-1:0]   dirty_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DATA_W-1:0] data_q [SETS][WORDS];

   // a line under refill stays invalid until its last word lands
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_en_i) begin
         valid_q[set_i] <= fill_last_i;
         dirty_q[set_i] <= 1'b0;
      end else if (wr_en_i) begin
         dirty_q[set_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en_i) begin
         data_q[set_i][fill_off_i] <= fill_data_i;
         if (fill_last_i) tag_q[set_i] <= tag_i;
      end
      if (wr_en_i) data_q[set_i][off_i] <= wr_data_i;
   end

   assign valid_o = valid_q[set_i];
   assign dirty_o = dirty_q[set_i];
   assign tag_o   = tag_q[set_i];
   assign hit_o   = valid_o && (tag_o == tag_i);
   assign word_o  = data_q[set_i][off_i];

   for (genvar w = 0; w < WORDS; w++) begin : g_line
      assign line_o[w*DATA_W +: DATA_W] = data_q[set_i][w];
   end
endmodule

// File: rtl/cwb_wbuf.sv
// One-line eviction buffer: captures a whole line in one cycle and
// drains it word by word over the memory write port.
module cwb_wbuf #(
   parameter int DATA_W   = 32,
   parameter int LINE_W   = 6,
   parameter int OFF_BITS = 2,
   localparam int WORDS   = 1 << OFF_BITS
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push_i,
   input  logic [LINE_W-1:0]          push_line_i,
   input  logic [WORDS*DATA_W-1:0]    push_data_i,
   output logic                       busy_o,
   output logic [LINE_W-1:0]          line_o,
   output logic                       mem_wr_req,
   output logic [LINE_W+OFF_BITS-1:0] mem_wr_addr,
   output logic [DATA_W-1:0]          mem_wr_data,
   input  logic                       mem_wr_ack
);
   logic                    busy_q;
   logic [LINE_W-1:0]       line_q;
   logic [WORDS*DATA_W-1:0] data_q;
   logic [OFF_BITS-1:0]     cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         line_q <= '0;
         data_q <= '0;
         cnt_q  <= '0;
      end else if (push_i && !busy_q) begin
         busy_q <= 1'b1;
         line_q <= push_line_i;
         data_q <= push_data_i;
         cnt_q  <= '0;
      end else if (busy_q && mem_wr_ack) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == '1) busy_q <= 1'b0;
      end
   end

   assign busy_o      = busy_q;
   assign line_o      = line_q;
   assign mem_wr_req  = busy_q;
   assign mem_wr_addr = {line_q, cnt_q};
   assign mem_wr_data = data_q[cnt_q*DATA_W +: DATA_W];
endmodule

// File: rtl/cwb_cache.sv
// Two-way set-associative copy-back cache: lookup, victim choice,
// recency bits, refill sequencing and hand-off to the eviction buffer.
module cwb_cache #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int SET_BITS = 2,
   parameter int OFF_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_ack,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   input  logic              mem_wr_ack
);
   import cwb_pkg::*;

   localparam int TAG_W  = ADDR_W - SET_BITS - OFF_BITS;
   localparam int LINE_W = ADDR_W - OFF_BITS;
   localparam int SETS   = 1 << SET_BITS;
   localparam int WORDS  = 1 << OFF_BITS;

   if (TAG_W < 1) begin : g_bad_split
      $error("cwb_cache: address too narrow for set and offset fields");
   end
   if (DATA_W < 1 || OFF_BITS < 1 || SET_BITS < 1) begin : g_bad_size
      $error("cwb_cache: widths must be positive");
   end

   logic [OFF_BITS-1:0] req_off;
   logic [SET_BITS-1:0] req_set;
   logic [TAG_W-1:0]    req_tag;
   logic [LINE_W-1:0]   req_line;
   assign req_off  = req_addr[OFF_BITS-1:0];
   assign req_set  = req_addr[OFF_BITS +: SET_BITS];
   assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
   assign req_line = req_addr[ADDR_W-1:OFF_BITS];

   cwb_state_t          state_q;
   logic [OFF_BITS-1:0] cnt_q;
   logic                fill_way_q;
   logic [SETS-1:0]     lru_q;       // way to displace next, per set

   logic [WAYS-1:0]         hit_w, valid_w, dirty_w, wr_en_w, fill_en_w;
   logic [TAG_W-1:0]        tag_w  [WAYS];
   logic [DATA_W-1:0]       word_w [WAYS];
   logic [WORDS*DATA_W-1:0] line_w [WAYS];

   logic look, any_hit, hit_way, victim, victim_dirty, fill_fire, fill_last;
   logic wb_busy, wb_match, miss_go;
   logic [LINE_W-1:0] wb_line;

   assign fill_last = (cnt_q == '1);
   assign fill_fire = (state_q == ST_FILL) && mem_rd_ack;

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      assign wr_en_w[g]   = cpu_done && req_write && hit_w[g];
      assign fill_en_w[g] = fill_fire && (fill_way_q == 1'(g));
      cwb_way #(
         .DATA_W(DATA_W), .SET_BITS(SET_BITS), .OFF_BITS(OFF_BITS), .TAG_W(TAG_W)
      ) u_way (
         .clk(clk), .rst_n(rst_n),
         .set_i(req_set), .off_i(req_off), .tag_i(req_tag),
         .hit_o(hit_w[g]), .valid_o(valid_w[g]), .dirty_o(dirty_w[g]),
         .tag_o(tag_w[g]), .word_o(word_w[g]), .line_o(line_w[g]),
         .wr_en_i(wr_en_w[g]), .wr_data_i(req_wdata),
         .fill_en_i(fill_en_w[g]), .fill_last_i(fill_last),
         .fill_off_i(cnt_q), .fill_data_i(mem_rd_data)
      );
   end

   assign look    = (state_q == ST_LOOK) && req_valid;
   assign any_hit = |hit_w;
   assign hit_way = hit_w[1];

   // invalid ways are filled first, then the least recently used one
   assign victim       = !valid_w[0] ? 1'b0 : (!valid_w[1] ? 1'b1 : lru_q[req_set]);
   assign victim_dirty = valid_w[victim] && dirty_w[victim];
   assign wb_match     = wb_busy && (wb_line == req_line);
   assign miss_go      = look && !any_hit && !(wb_busy && (victim_dirty || wb_match));

   assign cpu_done = look && any_hit;

   always_comb begin
      cpu_rdata = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_w[w]) cpu_rdata = cpu_rdata | word_w[w];
      end
   end

   assign mem_rd_req  = (state_q == ST_FILL);
   assign mem_rd_addr = {req_line, cnt_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_LOOK;
         cnt_q      <= '0;
         fill_way_q <= 1'b0;
         lru_q      <= '0;
      end else begin
         case (state_q)
            ST_LOOK: begin
               if (cpu_done) lru_q[req_set] <= ~hit_way;
               if (miss_go) begin
                  state_q    <= ST_FILL;
                  cnt_q      <= '0;
                  fill_way_q <= victim;
               end
            end
            default: begin
               if (mem_rd_ack) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (fill_last) begin
                     state_q        <= ST_LOOK;
                     lru_q[req_set] <= ~fill_way_q;
                  end
               end
            end
         endcase
      end
   end

   cwb_wbuf #(.DATA_W(DATA_W), .LINE_W(LINE_W), .OFF_BITS(OFF_BITS)) u_wbuf (
      .clk(clk), .rst_n(rst_n),
      .push_i(miss_go && victim_dirty),
      .push_line_i({tag_w[victim], req_set}),
      .push_data_i(line_w[victim]),
      .busy_o(wb_busy), .line_o(wb_line),
      .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
   );
endmodule

// File: rtl/cwb_checker.sv
module cwb_checker #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int OFF_BITS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              cpu_done,
   input logic              mem_rd_req,
   input logic              mem_rd_ack,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_wr_req,
   input logic              mem_wr_ack,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic [DATA_W-1:0] mem_wr_data
);
   AST_DONE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> req_valid);                                            // R2
   AST_QUIET_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !cpu_done);                                          // R3
   AST_FILL_FROM_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd_req) |-> mem_rd_addr[OFF_BITS-1:0] == '0);             // R3
   AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && mem_rd_ack && mem_rd_addr[OFF_BITS-1:0] != '1)
      |=> (mem_rd_req && mem_rd_addr == $past(mem_rd_addr) + 1'b1));       // R3
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr))); // R9
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && !mem_wr_ack)
      |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));   // R9
   AST_DRAIN_FROM_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_req) |-> mem_wr_addr[OFF_BITS-1:0] == '0);             // R6
   AST_NO_STALE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && mem_wr_req)
      |-> mem_rd_addr[ADDR_W-1:OFF_BITS] != mem_wr_addr[ADDR_W-1:OFF_BITS]); // R8
endmodule

bind cwb_cache cwb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_BITS(OFF_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cpu_done(cpu_done),
   .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack), .mem_rd_addr(mem_rd_addr),
   .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack), .mem_wr_addr(mem_wr_addr),
   .mem_wr_data(mem_wr_data)
);

// File: tb/cwb_cache_bench.sv
module cwb_cache_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        cpu_done;
   logic [31:0] cpu_rdata;
   logic        mem_rd_req, mem_wr_req;
   logic [7:0]  mem_rd_addr, mem_wr_addr;
   logic [31:0] mem_wr_data;
   logic        mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
   logic [31:0] mem_rd_data = '0;

   int n_checks = 0, n_err = 0, rd_cnt = 0, wr_cnt = 0;
   logic [31:0] mem [256];
   logic [7:0]  rd_log [64];
   logic [7:0]  wr_log [64];
   bit          hold_wr = 1'b0;
   bit          acc_done;

   always #10 clk = ~clk;   // 50 MHz

   cwb_cache u_cwb_cache (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .cpu_done(cpu_done),
      .cpu_rdata(cpu_rdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
   );

   function automatic logic [31:0] init_word(input int a);
      return 32'h5A00_0000 + 32'(a);
   endfunction

   // memory model: acknowledges every other cycle, away from the clock edge
   initial begin
      for (int i = 0; i < 256; i++) mem[i] = init_word(i);
      forever begin
         @(negedge clk);
         if (mem_rd_req && !mem_rd_ack) begin
            mem_rd_ack  = 1'b1;
            mem_rd_data = mem[mem_rd_addr];
         end else mem_rd_ack = 1'b0;
         if (mem_wr_req && !mem_wr_ack && !hold_wr) begin
            mem_wr_ack = 1'b1;
            mem[mem_wr_addr] = mem_wr_data;
         end else mem_wr_ack = 1'b0;
      end
   end

   initial forever begin
      @(posedge clk);
      if (mem_rd_req && mem_rd_ack) begin rd_log[rd_cnt % 64] = mem_rd_addr; rd_cnt++; end
      if (mem_wr_req && mem_wr_ack) begin wr_log[wr_cnt % 64] = mem_wr_addr; wr_cnt++; end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output int lat);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
      lat = 0;
      #1;
      while (!cpu_done) begin
         @(negedge clk); #1;
         lat++;
      end
      rd = cpu_rdata;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 done low after reset", 32'(cpu_done), 0);
      check("R1 no fetch after reset", 32'(mem_rd_req), 0);
      check("R1 no write after reset", 32'(mem_wr_req), 0);
   endtask

   task automatic t_fill;
      logic [31:0] d; int lat; int r0;
      r0 = rd_cnt;
      access(0, 8'h05, 0, d, lat);
      check("R1 first access misses", 32'(lat > 0), 1);
      check("R3 four words fetched", 32'(rd_cnt - r0), 4);
      for (int i = 0; i < 4; i++)
         check("R3 fetch order", 32'(rd_log[(r0 + i) % 64]), 32'(8'h04 + i));
      check("R3 replayed read data", d, init_word(8'h05));
   endtask

   task automatic t_hit;
      logic [31:0] d; int lat; int r0;
      r0 = rd_cnt;
      access(0, 8'h06, 0, d, lat);
      check("R2 hit latency", 32'(lat), 0);
      check("R2 hit no fetch", 32'(rd_cnt - r0), 0);
      check("R2 hit data", d, init_word(8'h06));
   endtask

   task automatic t_write_hit;
      logic [31:0] d; int lat; int w0;
      w0 = wr_cnt;
      access(1, 8'h07, 32'hDEAD_0007, d, lat);
      check("R5 write hit latency", 32'(lat), 0);
      access(0, 8'h07, 0, d, lat);
      check("R5 write hit readback", d, 32'hDEAD_0007);
      check("R5 memory untouched", mem[8'h07], init_word(8'h07));
      check("R5 no memory write", 32'(wr_cnt - w0), 0);
   endtask

   task automatic t_lru;
      logic [31:0] d; int lat; int w0;
      w0 = wr_cnt;
      access(0, 8'h08, 0, d, lat);   // way0
      access(0, 8'h18, 0, d, lat);   // way1
      access(0, 8'h09, 0, d, lat);   // touch way0
      check("R4 touched line hits", 32'(lat), 0);
      access(0, 8'h28, 0, d, lat);   // displaces 0x18
      check("R4 third line misses", 32'(lat > 0), 1);
      check("R4 third line data", d, init_word(8'h28));
      access(0, 8'h0A, 0, d, lat);
      check("R4 recently used line kept", 32'(lat), 0);
      access(0, 8'h1B, 0, d, lat);
      check("R4 least recent line displaced", 32'(lat > 0), 1);
      check("R6 clean eviction writes nothing", 32'(wr_cnt - w0), 0);
   endtask

   task automatic t_write_miss;
      logic [31:0] d; int lat; int r0;
      r0 = rd_cnt;
      access(1, 8'h31, 32'hBEEF_0031, d, lat);
      check("R10 write miss fetches line", 32'(rd_cnt - r0), 4);
      access(0, 8'h31, 0, d, lat);
      check("R10 written word", d, 32'hBEEF_0031);
      access(0, 8'h30, 0, d, lat);
      check("R10 neighbour word", d, init_word(8'h30));
      check("R10 memory untouched", mem[8'h31], init_word(8'h31));
   endtask

   task automatic t_writeback;
      logic [31:0] d; int lat; int w0;
      w0 = wr_cnt;
      access(0, 8'h14, 0, d, lat);   // fills invalid way1 of set 1
      hold_wr = 1'b1;
      access(0, 8'h24, 0, d, lat);   // displaces dirty line 0x04..0x07
      check("R7 access done before drain", 32'(wr_cnt - w0), 0);
      check("R7 displacing read data", d, init_word(8'h24));
      @(negedge clk);
      check("R6 buffer requesting write", 32'(mem_wr_req), 1);
      check("R6 write at victim base", 32'(mem_wr_addr), 32'h04);
   endtask

   task automatic t_conflict;
      logic [31:0] d; int lat; int r0; int w0;
      r0 = rd_cnt; w0 = wr_cnt; acc_done = 1'b0;
      fork
         begin access(0, 8'h07, 0, d, lat); acc_done = 1'b1; end
      join_none
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); #2;
         if (cpu_done || rd_cnt != r0) begin
            check("R8 miss waits for buffer", 32'(cpu_done), 0);
            check("R8 no fetch while buffered", 32'(rd_cnt - r0), 0);
         end
      end
      check("R8 still waiting", 32'(acc_done), 0);
      hold_wr = 1'b0;
      wait (acc_done);
      check("R8 data from written-back line", d, 32'hDEAD_0007);
      check("R6 four words written", 32'(wr_cnt - w0), 4);
      for (int i = 0; i < 4; i++)
         check("R6 write order", 32'(wr_log[(w0 + i) % 64]), 32'(8'h04 + i));
      check("R6 modified word in memory", mem[8'h07], 32'hDEAD_0007);
      check("R6 other word in memory", mem[8'h05], init_word(8'h05));
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill();
      t_hit();
      t_write_hit();
      t_lru();
      t_write_miss();
      t_writeback();
      t_conflict();
      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end
endmodule